// File: doc/BRIEF.md
# D-Channel Access Priority Arbiter

This block decides when a local HDLC transmitter may begin a frame on a D channel that several terminals share in the upstream direction. On every bit-rate strobe it samples the bit echoed back from the line and counts consecutive ones. A pending frame request is granted once that count reaches the number the current priority needs. The needed count depends on two things. The first is a class select bit, where signalling priority needs fewer ones than data priority. The second is a priority level that the block manages by itself.

After a frame ends cleanly, the block drops to the lower level of its class, so that other terminals get a turn. It returns to the normal level once the line has shown the longer run of ones. While a frame is being sent, the block compares each echoed bit with the bit it sent. On the first mismatch it raises a one-cycle collision-abort pulse, releases the grant and starts counting again from zero. A collision does not change the level.

Top module: `dch_access_arbiter`

## Requirements
- R1: After reset, grant and coll_abort are low, the class is signalling (class 1) and the level is normal, so a requested grant needs 8 consecutive ones.
- R2: With class_sig=1 (signalling) at normal level, a pending request is granted one clock after the 8th consecutive one. Seven ones do not grant.
- R3: With class_sig=0 (data) at normal level, a grant needs 10 consecutive ones. Nine ones do not grant.
- R4: An echo_bit of 0 sampled on a strobe while waiting resets the run of ones to zero.
- R5: A frame_end while granted drops grant on the next clock and selects the lower level. The lower level needs 9 ones for class 1 and 11 ones for class 2.
- R6: At the lower level, once the run of ones reaches the lower-level count while not granted, the level returns to normal, even with no request pending.
- R7: While granted, a strobe with echo_bit different from sent_bit drops grant on the next clock and raises coll_abort for exactly that one cycle. The run restarts from zero and the level is unchanged.
- R8: class_sig is taken into account only while grant is low. Changes to it during a frame have no effect.
- R9: grant never rises without frame_req asserted on the preceding clock.
- R10: echo_bit is ignored on clocks where bit_strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | One-clock pulse per D-channel bit period |
| echo_bit | input | 1 | Bit echoed back from the shared upstream line |
| sent_bit | input | 1 | Bit the local transmitter is driving |
| class_sig | input | 1 | 1 = signalling priority (class 1), 0 = data priority (class 2) |
| frame_req | input | 1 | Local transmitter has a frame waiting |
| frame_end | input | 1 | Current frame finished without error |
| grant | output | 1 | Transmitter may send |
| coll_abort | output | 1 | One-cycle pulse: collision detected, frame must abort |

## Verification
Several properties are checked on every clock. coll_abort is a single-cycle pulse that never coincides with grant. A rising grant is always preceded by a request and by a run count at or above the active threshold. A zero echo on a strobe clears the counter. A clean frame end always leaves the lower level selected. The class also stays frozen while a frame is in progress. The exact counts of 8, 9, 10 and 11, the return to the normal level after a long idle run, the level being kept across a collision, and the gating by the strobe are shown only by the bench's directed scenarios and by its cycle-by-cycle comparison against a reference model under random traffic.

// File: rtl/dch_pkg.sv
package dch_pkg;

    typedef enum logic {
        ST_LISTEN = 1'b0,
        ST_SEND   = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic strobe;
        logic echo;
        logic sent;
    } line_smp_t;

    // ones required for a given class/level combination
    function automatic int unsigned ones_needed(
        input logic        sig_class,
        input logic        low_level,
        input int unsigned cls1_norm,
        input int unsigned cls2_norm,
        input int unsigned low_step
    );
        int unsigned base;
        base = sig_class ? cls1_norm : cls2_norm;
        return low_level ? base + low_step : base;
    endfunction

endpackage

// File: rtl/dch_ones_counter.sv
module dch_ones_counter #(
    parameter int unsigned MAX_CNT = 11,
    parameter int unsigned CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             strobe,
    input  logic             echo,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_CNT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (strobe) begin
            if (!echo)
                cnt <= '0;
            else if (cnt != SAT)
                cnt <= cnt + 1'b1;
        end
    end

    AST_ZERO_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (strobe && !echo && !clear) |=> (cnt == '0)); // R4

    AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !clear) |=> $stable(cnt)); // R10

endmodule

// File: rtl/dch_level_ctrl.sv
module dch_level_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_low,
    input  logic back_normal,
    output logic low_level
);
    always_ff @(posedge clk) begin
        if (rst)
            low_level <= 1'b0;
        else if (set_low)
            low_level <= 1'b1;
        else if (back_normal)
            low_level <= 1'b0;
    end

    AST_LOW_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        set_low |=> low_level); // R5

endmodule

// File: rtl/dch_access_fsm.sv
module dch_access_fsm
    import dch_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_smp_t line,
    input  logic      frame_req,
    input  logic      frame_end,
    input  logic      class_sig,
    input  logic      thr_met,
    output logic      grant,
    output logic      grant_go,
    output logic      coll_abort,
    output logic      done_ok,
    output logic      cls_q
);
    arb_state_e state_q;
    logic       collide;

    assign grant    = (state_q == ST_SEND);
    assign grant_go = !grant && frame_req && thr_met;
    assign collide  = grant && line.strobe && (line.echo != line.sent);
    assign done_ok  = grant && frame_end && !collide;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_LISTEN;
            coll_abort <= 1'b0;
            cls_q      <= 1'b1;
        end else begin
            coll_abort <= collide;
            if (!grant)
                cls_q <= class_sig;
            unique case (state_q)
                ST_LISTEN: if (grant_go) state_q <= ST_SEND;
                ST_SEND:   if (collide || done_ok) state_q <= ST_LISTEN;
                default:   state_q <= ST_LISTEN;
            endcase
        end
    end

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> $past(frame_req)); // R9

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        coll_abort |=> !coll_abort); // R7

    AST_ABORT_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        coll_abort |-> !grant); // R7

    AST_CLASS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $past(grant) |-> $stable(cls_q)); // R8

endmodule

// File: rtl/dch_access_arbiter.sv
module dch_access_arbiter
    import dch_pkg::*;
#(
    parameter int unsigned CLS1_NORM = 8,
    parameter int unsigned CLS2_NORM = 10,
    parameter int unsigned LOW_STEP  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_strobe,
    input  logic echo_bit,
    input  logic sent_bit,
    input  logic class_sig,
    input  logic frame_req,
    input  logic frame_end,
    output logic grant,
    output logic coll_abort
);
    localparam int unsigned TOP_CNT =
        ((CLS1_NORM > CLS2_NORM) ? CLS1_NORM : CLS2_NORM) + LOW_STEP;
    localparam int unsigned CNT_W = $clog2(TOP_CNT + 1);

    line_smp_t        line;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] thr_now;
    logic [CNT_W-1:0] thr_low;
    logic             low_level;
    logic             cls_q;
    logic             grant_go;
    logic             done_ok;
    logic             back_normal;

    assign line = '{strobe: bit_strobe, echo: echo_bit, sent: sent_bit};

    assign thr_now = CNT_W'(ones_needed(cls_q, low_level, CLS1_NORM, CLS2_NORM, LOW_STEP));
    assign thr_low = CNT_W'(ones_needed(cls_q, 1'b1, CLS1_NORM, CLS2_NORM, LOW_STEP));
    assign back_normal = !grant && low_level && (run_cnt >= thr_low);

    dch_ones_counter #(
        .MAX_CNT (TOP_CNT),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (grant | grant_go),
        .strobe (bit_strobe),
        .echo   (echo_bit),
        .cnt    (run_cnt)
    );

    dch_level_ctrl u_lvl (
        .clk         (clk),
        .rst         (rst),
        .set_low     (done_ok),
        .back_normal (back_normal),
        .low_level   (low_level)
    );

    dch_access_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .line       (line),
        .frame_req  (frame_req),
        .frame_end  (frame_end),
        .class_sig  (class_sig),
        .thr_met    (run_cnt >= thr_now),
        .grant      (grant),
        .grant_go   (grant_go),
        .coll_abort (coll_abort),
        .done_ok    (done_ok),
        .cls_q      (cls_q)
    );

    AST_GRANT_AT_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> ($past(run_cnt) >= $past(thr_now))); // R2

    AST_RUN_HELD_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
        $past(grant) |-> (run_cnt == '0)); // R7

endmodule

// File: tb/sim_dch_access_arbiter.sv
`timescale 1ns/1ps
module sim_dch_access_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_strobe = 0, echo_bit = 1, sent_bit = 1, class_sig = 1;
    logic frame_req = 0, frame_end = 0;
    logic grant, coll_abort;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int   m_cnt;
    logic m_low, m_cls, m_act, m_coll;

    always #2.5 clk = ~clk;

    dch_access_arbiter u0 (
        .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .echo_bit(echo_bit),
        .sent_bit(sent_bit), .class_sig(class_sig), .frame_req(frame_req),
        .frame_end(frame_end), .grant(grant), .coll_abort(coll_abort)
    );

    function automatic int need(input logic cls1, input logic low);
        return (cls1 ? 8 : 10) + (low ? 1 : 0);
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_low = 0; m_cls = 1; m_act = 0; m_coll = 0;
    endtask

    task automatic model_edge();
        logic cls_old, low_old;
        cls_old = m_cls; low_old = m_low;
        m_coll = 0;
        if (!m_act) begin
            m_cls = class_sig;
            if (low_old && m_cnt >= need(cls_old, 1'b1)) m_low = 0;
            if (frame_req && m_cnt >= need(cls_old, low_old)) begin
                m_act = 1; m_cnt = 0;
            end else if (bit_strobe) begin
                m_cnt = echo_bit ? ((m_cnt < 11) ? m_cnt + 1 : 11) : 0;
            end
        end else begin
            if (bit_strobe && echo_bit != sent_bit) begin
                m_act = 0; m_coll = 1; m_cnt = 0;
            end else if (frame_end) begin
                m_act = 0; m_low = 1; m_cnt = 0;
            end
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic en, input logic ec, input logic tx,
                        input logic cs, input logic rq, input logic fe);
        bit_strobe = en; echo_bit = ec; sent_bit = tx;
        class_sig = cs; frame_req = rq; frame_end = fe;
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic ones(input int n, input logic cs, input logic rq);
        for (int i = 0; i < n; i++) step(1, 1, 1, cs, rq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 grant after reset", grant, 1'b0);
        chk("R1 abort after reset", coll_abort, 1'b0);

        // R2 / R1: class 1 normal needs 8
        ones(7, 1, 1); step(0, 1, 1, 1, 1, 0);
        chk("R2 seven ones", grant, 1'b0);
        ones(1, 1, 1); chk("R2 grant lags count", grant, 1'b0);
        step(0, 1, 1, 1, 1, 0);
        chk("R2 eight ones grant", grant, 1'b1);

        // R5: clean end -> lower level needs 9
        step(0, 1, 1, 1, 0, 1);
        chk("R5 grant drops on end", grant, 1'b0);
        ones(8, 1, 1); step(0, 1, 1, 1, 1, 0);
        chk("R5 eight ones at low level", grant, 1'b0);
        ones(1, 1, 1); step(0, 1, 1, 1, 1, 0);
        chk("R5 nine ones at low level", grant, 1'b1);

        // R7: collision
        step(1, 0, 1, 1, 1, 0);
        chk("R7 abort pulse", coll_abort, 1'b1);
        chk("R7 grant dropped", grant, 1'b0);
        step(0, 1, 1, 1, 0, 0);
        chk("R7 abort one cycle", coll_abort, 1'b0);
        ones(8, 1, 1); step(0, 1, 1, 1, 1, 0);
        chk("R7 level kept normal", grant, 1'b1);

        // R6 / R9: back to normal without request
        step(0, 1, 1, 1, 0, 1);
        ones(10, 1, 0); step(0, 1, 1, 1, 0, 0);
        chk("R9 no grant without request", grant, 1'b0);
        step(1, 0, 0, 1, 0, 0);
        // R4 mixed in: 5 ones, a zero, then 7 ones not enough
        ones(5, 1, 1); step(1, 0, 0, 1, 1, 0);
        ones(7, 1, 1); step(0, 1, 1, 1, 1, 0);
        chk("R4 zero restarts run", grant, 1'b0);
        ones(1, 1, 1); step(0, 1, 1, 1, 1, 0);
        chk("R6 normal level regained", grant, 1'b1);
        step(1, 1, 0, 1, 0, 0); // collision, level stays normal

        // R10: strobe gating
        ones(4, 1, 1); step(0, 0, 0, 1, 1, 0);
        ones(4, 1, 1); step(0, 1, 1, 1, 1, 0);
        chk("R10 unstrobed zero ignored", grant, 1'b1);

        // R8: class change during frame ignored
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 0, 0);
        chk("R8 grant holds across class change", grant, 1'b1);
        step(1, 0, 1, 1, 0, 0);

        // R3: class 2 normal needs 10
        ones(9, 0, 1); step(0, 1, 1, 0, 1, 0);
        chk("R3 nine ones class 2", grant, 1'b0);
        ones(1, 0, 1); step(0, 1, 1, 0, 1, 0);
        chk("R3 ten ones class 2", grant, 1'b1);
        step(0, 1, 1, 0, 0, 1);
        ones(10, 0, 1); step(0, 1, 1, 0, 1, 0);
        chk("R5 class 2 low needs 11", grant, 1'b0);
        ones(1, 0, 1); step(0, 1, 1, 0, 1, 0);
        chk("R5 class 2 eleven ones", grant, 1'b1);

        // random traffic against the model (R2 R3 R5 R6 R7 R8 R10)
        void'($urandom(32'h1D5C));
        for (int i = 0; i < 4000; i++) begin
            logic en, ec, tx, cs, rq, fe;
            en = ($urandom % 3) != 0;
            ec = ($urandom % 10) != 0;
            tx = (($urandom % 20) == 0) ? ~ec : ec;
            cs = (($urandom % 200) == 0) ? ~class_sig : class_sig;
            rq = ($urandom % 4) != 0;
            fe = ($urandom % 25) == 0;
            step(en, ec, tx, cs, rq, fe);
            chk("R2/R3/R5/R6/R8 random grant", grant, m_act);
            chk("R7 random abort", coll_abort, m_coll);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule